// File: doc/BRIEF.md
# Saturating Vector Adder-Subtracter with Memory Addressing

This block walks two operand vectors held in external memory and writes their element-wise sum or difference to a third vector in memory. Each vector has its own base address, so the block drives two read-address streams and one write-address stream. A single start pulse launches the operation. It carries the vector length, the three base addresses and the operation selector, and the block captures all of them on that pulse.

Operands and results are 16-bit two's-complement fixed point with one integer bit and fifteen fractional bits (Q1.15). Results that fall outside the representable range are clamped and never wrap.

The read memories answer an address one cycle after it is presented. The block registers each result and writes it one cycle after its operands arrive. While any element is still in flight, the idle output is low. When idle is high, the block can accept a new start.

Top module: `vec_addsub_engine`

## Requirements
- R1: After reset, `idle` is 1 and `wr_en` is 0.
- R2: A start accepted in cycle 0 with length N drives `rd_addr_a = base_a + i` and `rd_addr_b = base_b + i` in cycle 1 + i, for i = 0 .. N-1. Addresses are ADDR_W-bit and wrap modulo 2^ADDR_W.
- R3: With `mode_sub` = 0 at start, each result is the Q1.15 sum a + b. A sum above 0x7FFF gives 0x7FFF and a sum below 0x8000 gives 0x8000. Two non-negative operands never give a negative result.
- R4: With `mode_sub` = 1 at start, each result is a − b, with the same clamping to 0x7FFF / 0x8000.
- R5: For element i, `wr_en` is 1 in cycle 3 + i with `wr_addr = base_z + i` and the result on `wr_data`. `wr_en` is high for exactly N consecutive cycles per run.
- R6: `idle` is 0 in cycles 1 .. N+2 and returns to 1 in cycle N+3, right after the last write.
- R7: A start while `idle` is 0 is ignored: the running sequence, its mode and its length continue unchanged.
- R8: Length, bases and mode are captured at start. Changing them later has no effect on the current run.
- R9: A start with length 0 performs no write and leaves `idle` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| mode_sub | input | 1 | 0 = add, 1 = subtract (a − b), captured at start |
| vec_len | input | LEN_W | Number of elements, captured at start |
| base_a | input | ADDR_W | Base address of operand vector a |
| base_b | input | ADDR_W | Base address of operand vector b |
| base_z | input | ADDR_W | Base address of the result vector |
| rd_data_a | input | DATA_W | Element of a, one cycle after its address |
| rd_data_b | input | DATA_W | Element of b, one cycle after its address |
| rd_addr_a | output | ADDR_W | Read address for vector a |
| rd_addr_b | output | ADDR_W | Read address for vector b |
| wr_addr | output | ADDR_W | Write address for the result |
| wr_data | output | DATA_W | Saturated result |
| wr_en | output | 1 | Write strobe |
| idle | output | 1 | High when no element is in flight |

## Verification
A new start can coincide with an operation that is still in progress: issuing, waiting for data, or writing the last elements. The bench raises a second start with a different length, mode and bases in the third cycle of a run. During the run it also scrambles the launch inputs every cycle. It judges the outcome by comparing every read address, write address and write value against the first start's parameters, and by requiring the idle-low window to last exactly N+2 cycles. Saturation is provoked at the extremes (0x7FFF + 1, 0x8000 − 1, 0 − 0x8000) in both modes and is checked at the write port.

// File: rtl/vas_pkg.sv
package vas_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    localparam int NUM_STREAMS = 3;
    localparam int STRM_A      = 0;
    localparam int STRM_B      = 1;
    localparam int STRM_Z      = 2;
endpackage

// File: rtl/vas_addr_gen.sv
module vas_addr_gen #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = base;
        end else if (step) begin
            addr_d = addr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/vas_sat_addsub.sv
module vas_sat_addsub
    import vas_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  op_e               op,
    output logic [DATA_W-1:0] y
);
    localparam int EXT_W = DATA_W + 1;
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [EXT_W-1:0] a_ext, b_ext, raw;

    always_comb begin
        a_ext = {a[DATA_W-1], a};
        b_ext = {b[DATA_W-1], b};
        if (op == OP_SUB) begin
            raw = a_ext - b_ext;
        end else begin
            raw = a_ext + b_ext;
        end
        if (raw[EXT_W-1] != raw[EXT_W-2]) begin
            y = raw[EXT_W-1] ? MAX_NEG : MAX_POS;
        end else begin
            y = raw[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/vec_addsub_engine.sv
module vec_addsub_engine
    import vas_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_sub,
    input  logic [LEN_W-1:0]  vec_len,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [ADDR_W-1:0] base_z,
    input  logic [DATA_W-1:0] rd_data_a,
    input  logic [DATA_W-1:0] rd_data_b,
    output logic [ADDR_W-1:0] rd_addr_a,
    output logic [ADDR_W-1:0] rd_addr_b,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              idle
);
    typedef struct packed {
        logic              issue_v;
        logic              data_v;
        logic [LEN_W-1:0]  remain;
        op_e               op;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
    } state_t;

    state_t st_d, st_q;

    logic                               launch;
    logic                               idle_w;
    logic [DATA_W-1:0]                  sum_w;
    logic [NUM_STREAMS-1:0][ADDR_W-1:0] gen_base;
    logic [NUM_STREAMS-1:0][ADDR_W-1:0] gen_addr;
    logic [NUM_STREAMS-1:0]             gen_step;

    assign idle_w = !(st_q.issue_v || st_q.data_v || st_q.wr_en);
    assign launch = start && idle_w && (vec_len != '0);

    assign gen_base[STRM_A] = base_a;
    assign gen_base[STRM_B] = base_b;
    assign gen_base[STRM_Z] = base_z;
    assign gen_step[STRM_A] = st_q.issue_v;
    assign gen_step[STRM_B] = st_q.issue_v;
    assign gen_step[STRM_Z] = st_q.data_v;

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
        vas_addr_gen #(.ADDR_W(ADDR_W)) u_gen (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (launch),
            .base  (gen_base[g]),
            .step  (gen_step[g]),
            .addr  (gen_addr[g])
        );
    end

    vas_sat_addsub #(.DATA_W(DATA_W)) u_alu (
        .a  (rd_data_a),
        .b  (rd_data_b),
        .op (st_q.op),
        .y  (sum_w)
    );

    always_comb begin
        st_d = st_q;
        if (launch) begin
            st_d.issue_v = 1'b1;
            st_d.remain  = vec_len;
            st_d.op      = mode_sub ? OP_SUB : OP_ADD;
        end else if (st_q.issue_v) begin
            st_d.remain = st_q.remain - LEN_W'(1);
            if (st_q.remain == LEN_W'(1)) begin
                st_d.issue_v = 1'b0;
            end
        end
        st_d.data_v = st_q.issue_v;
        st_d.wr_en  = st_q.data_v;
        if (st_q.data_v) begin
            st_d.wr_addr = gen_addr[STRM_Z];
            st_d.wr_data = sum_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{issue_v: 1'b0, data_v: 1'b0, remain: '0, op: OP_ADD,
                      wr_en: 1'b0, wr_addr: '0, wr_data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr_a = gen_addr[STRM_A];
    assign rd_addr_b = gen_addr[STRM_B];
    assign wr_addr   = st_q.wr_addr;
    assign wr_data   = st_q.wr_data;
    assign wr_en     = st_q.wr_en;
    assign idle      = idle_w;
endmodule

// File: rtl/vas_addsub_chk.sv
module vas_addsub_chk
    import vas_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  vec_len,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en,
    input logic              idle,
    input logic              issue_v,
    input op_e               op_q
);
    // R2: read addresses advance by one per issued element
    p_rd_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_v && $past(issue_v) |->
            (rd_addr_a == $past(rd_addr_a) + ADDR_W'(1)) &&
            (rd_addr_b == $past(rd_addr_b) + ADDR_W'(1)));

    // R3: adding two non-negative operands never yields a negative result
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (op_q == OP_ADD) && !$past(rd_data_a[DATA_W-1]) &&
        !$past(rd_data_b[DATA_W-1]) |-> !wr_data[DATA_W-1]);

    // R5: a write lands two cycles after its read was issued
    p_wr_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(issue_v, 2));

    // R5: consecutive writes target consecutive addresses
    p_wr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + ADDR_W'(1));

    // R6: idle comes back only right after a write
    p_idle_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(wr_en));

    // R7: a start during a run leaves the captured mode alone
    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start && !idle |=> op_q == $past(op_q));

    // R9: a zero-length start keeps the block idle
    p_len0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start && idle && (vec_len == '0) |=> idle);
endmodule

bind vec_addsub_engine vas_addsub_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vec_len   (vec_len),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .idle      (idle),
    .issue_v   (st_q.issue_v),
    .op_q      (st_q.op)
);

// File: tb/test_vec_addsub_engine.sv
`timescale 1ns/1ps
module test_vec_addsub_engine;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 10;
    localparam int LEN_W  = 10;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              mode_sub = 1'b0;
    logic [LEN_W-1:0]  vec_len = '0;
    logic [ADDR_W-1:0] base_a = '0, base_b = '0, base_z = '0;
    logic [DATA_W-1:0] rd_data_a, rd_data_b;
    logic [ADDR_W-1:0] rd_addr_a, rd_addr_b, wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              wr_en, idle;

    logic [DATA_W-1:0] mem_a [DEPTH];
    logic [DATA_W-1:0] mem_b [DEPTH];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vec_addsub_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_vec_addsub_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sub(mode_sub), .vec_len(vec_len),
        .base_a(base_a), .base_b(base_b), .base_z(base_z),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .idle(idle)
    );

    always_ff @(posedge clk) begin
        rd_data_a <= mem_a[rd_addr_a];
        rd_data_b <= mem_b[rd_addr_b];
    end

    function automatic logic [DATA_W-1:0] ref_op(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b, bit sub);
        int s;
        s = sub ? (int'($signed(a)) - int'($signed(b))) : (int'($signed(a)) + int'($signed(b)));
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return DATA_W'(s);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(int n, logic [ADDR_W-1:0] ba, logic [ADDR_W-1:0] bb,
                           logic [ADDR_W-1:0] bz, bit sub, bit poke);
        int idle_low;
        int wr_cnt;
        logic [ADDR_W-1:0] ia;
        logic [ADDR_W-1:0] ib;
        logic [ADDR_W-1:0] iz;
        logic [DATA_W-1:0] exp;
        idle_low = 0;
        wr_cnt = 0;
        @(negedge clk);
        vec_len = LEN_W'(n); base_a = ba; base_b = bb; base_z = bz; mode_sub = sub;
        start = 1'b1;
        for (int k = 1; k <= n + 4; k++) begin
            @(negedge clk);
            if (!idle) idle_low++;
            if (k <= n) begin
                ia = ba + ADDR_W'(k - 1);
                ib = bb + ADDR_W'(k - 1);
                check(rd_addr_a == ia && rd_addr_b == ib, "R2", "read address a",
                      int'(rd_addr_a), int'(ia));
            end
            if (wr_en) wr_cnt++;
            if (k >= 3 && k <= n + 2) begin
                iz = bz + ADDR_W'(k - 3);
                ia = ba + ADDR_W'(k - 3);
                ib = bb + ADDR_W'(k - 3);
                exp = ref_op(mem_a[ia], mem_b[ib], sub);
                check(wr_en && wr_addr == iz, "R5", "write address", int'(wr_addr), int'(iz));
                check(wr_data == exp, sub ? "R4" : "R3", "write data", int'(wr_data), int'(exp));
            end
            if (k == n + 3) begin
                check(idle == 1'b1, "R6", "idle after last write", int'(idle), 1);
            end
            // R7 / R8: disturb launch inputs while running
            start = poke && (k == 2);
            vec_len = LEN_W'($urandom_range(1, 50));
            base_a = ADDR_W'($urandom); base_b = ADDR_W'($urandom); base_z = ADDR_W'($urandom);
            mode_sub = ~sub;
        end
        start = 1'b0;
        check(wr_cnt == n, "R5", "write count", wr_cnt, n);
        check(idle_low == n + 2, poke ? "R7" : "R6", "idle-low cycles", idle_low, n + 2);
    endtask

    task automatic run_zero();
        int writes;
        int busy;
        writes = 0;
        busy = 0;
        @(negedge clk);
        vec_len = '0; start = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (wr_en) writes++;
            if (!idle) busy++;
        end
        check(writes == 0, "R9", "writes for zero length", writes, 0);
        check(busy == 0, "R9", "idle-low cycles for zero length", busy, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < DEPTH; i++) begin
            mem_a[i] = DATA_W'($urandom);
            mem_b[i] = DATA_W'($urandom);
        end
        // directed saturation pairs at 900.. (a) and 950.. (b)
        mem_a[900] = 16'h7FFF; mem_b[950] = 16'h0001;
        mem_a[901] = 16'h8000; mem_b[951] = 16'hFFFF;
        mem_a[902] = 16'h8000; mem_b[952] = 16'h0001;
        mem_a[903] = 16'h7FFF; mem_b[953] = 16'h8000;
        mem_a[904] = 16'h0000; mem_b[954] = 16'h8000;
        mem_a[905] = 16'h4000; mem_b[955] = 16'h4000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(idle == 1'b1, "R1", "idle after reset", int'(idle), 1);
        check(wr_en == 1'b0, "R1", "wr_en after reset", int'(wr_en), 0);

        run_vec(6, 10'd900, 10'd950, 10'd500, 1'b0, 1'b0);   // R3 corners
        run_vec(6, 10'd900, 10'd950, 10'd520, 1'b1, 1'b0);   // R4 corners
        run_vec(1, 10'd1023, 10'd0, 10'd1023, 1'b0, 1'b0);
        run_vec(5, 10'd1021, 10'd1020, 10'd1022, 1'b1, 1'b0); // address wrap
        run_zero();
        run_vec(8, 10'd40, 10'd80, 10'd120, 1'b0, 1'b1);     // R7 start while busy
        run_vec(2, 10'd7, 10'd9, 10'd11, 1'b1, 1'b1);
        for (int r = 0; r < 24; r++) begin
            run_vec($urandom_range(1, 40), ADDR_W'($urandom), ADDR_W'($urandom),
                    ADDR_W'($urandom), 1'($urandom), 1'($urandom));
        end
        run_vec(300, 10'd100, 10'd600, 10'd300, 1'b1, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run not finished actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule